// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block lets a host program and read back the configuration registers of a video decoder datapath over a standard two-wire serial bus (I2C standard mode, up to 100 kbit/s). It is a target only. It never starts a transfer, never stretches the clock, and ignores the general-call address. The system clock samples SCL and SDA through a two-flop synchronizer and must run at least 8 times faster than SCL. The block drives the bus through one open-drain enable: while `sda_oe` is high, the pad pulls SDA low.

A write transfer has three parts: the device address with the R/W bit low, one byte that loads the register pointer, and then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. A read transfer first sets the pointer in the same way. The host then issues a repeated START with the R/W bit high, and the block streams registers out from the pointer, advancing after each byte. The pointer wraps from the last register (0x1B) back to 0x00. That last register is a read-only identity byte. The whole register bank is presented in parallel to the datapath.

The controller has ten states:

| State | Role | Leaves to |
|---|---|---|
| `S_IDLE` | Waits for START | `S_ADDR` on START |
| `S_ADDR` | Shifts in the address byte | `S_ADDR_ACK` on a match; `S_HOLD` otherwise |
| `S_ADDR_ACK` | Drives the acknowledge | `S_PTR` for a write; `S_RDATA` for a read |
| `S_PTR` | Receives the pointer byte | `S_PTR_ACK` |
| `S_PTR_ACK` | Drives the acknowledge | `S_WDATA` |
| `S_WDATA` | Receives one data byte | `S_WDATA_ACK`, which returns to `S_WDATA` |
| `S_RDATA` | Shifts out one byte | `S_RACK` |
| `S_RACK` | Samples the host's acknowledge | `S_RDATA` on ACK; `S_HOLD` on NACK |
| `S_HOLD` | Ignores the bus | `S_ADDR` on START, `S_IDLE` on STOP |

A STOP in any state leads to `S_IDLE`. A START in any state leads to `S_ADDR`.

Top module: `vcfg_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high. It moves the block to address reception with an empty bit count from any state. A STOP is SDA rising while SCL is high. It returns the block to idle from any state. After a STOP, SCL pulses without a new START produce no drive on SDA and change no register.
- R2: The first byte after START carries the 7-bit device address in bits 7..1 (default 0x44) and R/W in bit 0 (0 = write). On a match, the block pulls SDA low (`sda_oe`=1) during the ninth SCL period. Any other address, including the general-call address 0x00, gets no acknowledge, and the block stays off the bus until the next START.
- R3: In a write transfer, the byte after the address loads the register pointer and is acknowledged. Values of 28 (0x1C) or above load 0.
- R4: Each later byte in a write transfer is acknowledged and stored in the register at the pointer. The pointer then advances by one.
- R5: After register 0x1B has been written or read, the pointer becomes 0x00.
- R6: Register 0x1B always reads 0x12. A write to it is acknowledged but changes nothing.
- R7: After reset, every register holds 0x00 except the colour saturation register at address 0x05, which holds 0x9D. The pointer is 0x00.
- R8: After a repeated START with R/W = 1, the block sends the register at the pointer, most significant bit first, one bit per SCL period. The pointer advances after each byte sent.
- R9: If the host acknowledges a read byte (SDA low in the ninth period), the next register follows. If it does not, the block releases SDA and leaves it released until the next START or STOP, whatever SCL does.
- R10: `cfg_regs` carries register i on bits [8i+7:8i] at all times. The new value of a written register is visible there before the transfer's STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_regs | output | 224 | Whole register bank, register i at bits [8i+7:8i] |

## Verification
The embedded properties watch every cycle for the following:
- START and STOP force the controller's state.
- The pointer wraps from 0x1B to 0x00.
- A completed write byte lands in its register.
- A write to the identity address leaves the storage untouched.
- SDA is released after a non-acknowledged read byte.
- A non-matching address is never acknowledged.

Only the bench's scenarios can show end-to-end behaviour on the bus:
- Bytes written with a random length at a random pointer read back intact.
- Out-of-range pointers fall back to 0.
- A transfer cut short by STOP or by a repeated START in mid-byte leaves no stray write.
- Clock pulses on a transfer that was ignored or ended never produce a pull-down on SDA.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK,
        S_HOLD
    } vcfg_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } vcfg_bus_ev_t;

endpackage

// File: rtl/vcfg_line_sync.sv
module vcfg_line_sync
    import vcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output vcfg_bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_d     <= scl_s;
            sda_d     <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/vcfg_regfile.sv
module vcfg_regfile #(
    parameter int         NUM_REGS = 28,
    parameter int         PTR_W    = 5,
    parameter int         SAT_ADDR = 5,
    parameter logic [7:0] SAT_INIT = 8'h9D,
    parameter logic [7:0] ID_VALUE = 8'h12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);

    localparam int               NSTORE  = NUM_REGS - 1;
    localparam logic [PTR_W-1:0] ID_ADDR = PTR_W'(NUM_REGS - 1);

    logic [NSTORE*8-1:0] store_flat;

    for (genvar gi = 0; gi < NSTORE; gi++) begin : g_reg
        localparam logic [7:0]       RST_V = (gi == SAT_ADDR) ? SAT_INIT : 8'h00;
        localparam logic [PTR_W-1:0] MY_A  = PTR_W'(gi);
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_V;
            end else if (wr_en && wr_addr == MY_A) begin
                q <= wr_data;
            end
        end

        assign store_flat[gi*8 +: 8] = q;

        // R4: a completed write byte lands in the addressed register
        a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == MY_A) |=> (q == $past(wr_data)));
    end

    assign regs_flat = {ID_VALUE, store_flat};

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == PTR_W'(k)) begin
                rd_data = regs_flat[k*8 +: 8];
            end
        end
    end

    // R6: writing the identity address leaves every stored register untouched
    a_r6_id_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ID_ADDR) |=> $stable(store_flat));

endmodule

// File: rtl/vcfg_ctrl.sv
module vcfg_ctrl
    import vcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44,
    parameter int         NUM_REGS = 28,
    parameter int         PTR_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vcfg_bus_ev_t     ev,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    localparam logic [PTR_W-1:0] LAST_A = PTR_W'(NUM_REGS - 1);
    localparam logic [7:0]       NREG_B = 8'(NUM_REGS);

    vcfg_state_e      state_q;
    vcfg_state_e      state_d;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       rx_q;
    logic [7:0]       tx_q;
    logic [PTR_W-1:0] ptr_q;
    logic             rw_q;
    logic             mack_q;

    logic             byte_end;
    logic             addr_hit;
    logic             ptr_step;
    logic             in_ack;
    logic             in_count;
    logic             in_rx;
    logic [PTR_W-1:0] ptr_inc;

    assign byte_end = ev.scl_fall && (bit_cnt_q == 4'd8);
    assign addr_hit = (rx_q[7:1] == DEV_ADDR) && (rx_q[7:1] != 7'd0);
    assign ptr_inc  = (ptr_q == LAST_A) ? '0 : ptr_q + 1'b1;
    assign ptr_step = byte_end && (state_q == S_WDATA || state_q == S_RDATA);
    assign in_ack   = (state_q == S_ADDR_ACK) || (state_q == S_PTR_ACK) ||
                      (state_q == S_WDATA_ACK) || (state_q == S_RACK);
    assign in_rx    = (state_q == S_ADDR) || (state_q == S_PTR) || (state_q == S_WDATA);
    assign in_count = in_rx || (state_q == S_RDATA);

    // next state
    always_comb begin
        state_d = state_q;
        if (ev.stop) begin
            state_d = S_IDLE;
        end else if (ev.start) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE, S_HOLD: ;
                S_ADDR:      if (byte_end)    state_d = addr_hit ? S_ADDR_ACK : S_HOLD;
                S_ADDR_ACK:  if (ev.scl_fall) state_d = rw_q ? S_RDATA : S_PTR;
                S_PTR:       if (byte_end)    state_d = S_PTR_ACK;
                S_PTR_ACK:   if (ev.scl_fall) state_d = S_WDATA;
                S_WDATA:     if (byte_end)    state_d = S_WDATA_ACK;
                S_WDATA_ACK: if (ev.scl_fall) state_d = S_WDATA;
                S_RDATA:     if (byte_end)    state_d = S_RACK;
                S_RACK:      if (ev.scl_fall) state_d = mack_q ? S_RDATA : S_HOLD;
                default:                      state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // byte datapath: counters, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= 4'd0;
            rx_q      <= 8'h00;
            tx_q      <= 8'h00;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
        end else begin
            if (ev.start || ev.stop) begin
                bit_cnt_q <= 4'd0;
            end else if (ev.scl_fall && (bit_cnt_q == 4'd8 || in_ack)) begin
                bit_cnt_q <= 4'd0;
            end else if (ev.scl_rise && in_count && bit_cnt_q != 4'd8) begin
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end

            if (ev.scl_rise && in_rx) begin
                rx_q <= {rx_q[6:0], ev.sda};
            end

            if (state_q == S_ADDR && byte_end) begin
                rw_q <= rx_q[0];
            end

            if (state_q == S_PTR && byte_end) begin
                ptr_q <= (rx_q < NREG_B) ? rx_q[PTR_W-1:0] : '0;
            end else if (ptr_step) begin
                ptr_q <= ptr_inc;
            end

            if (state_q == S_ADDR_ACK && ev.scl_fall && rw_q) begin
                tx_q <= rd_data;
            end else if (state_q == S_RACK && ev.scl_fall && mack_q) begin
                tx_q <= rd_data;
            end else if (state_q == S_RDATA && ev.scl_fall && bit_cnt_q != 4'd8) begin
                tx_q <= {tx_q[6:0], 1'b0};
            end

            if (state_q == S_RACK && ev.scl_rise) begin
                mack_q <= ~ev.sda;
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr = ptr_q;
        wr_addr = ptr_q;
        wr_data = rx_q;
        wr_en   = (state_q == S_WDATA) && byte_end;
        unique case (state_q)
            S_ADDR_ACK, S_PTR_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                            sda_oe = ~tx_q[7];
            default:                            sda_oe = 1'b0;
        endcase
    end

    // R1: START restarts address reception with an empty bit count
    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> (state_q == S_ADDR && bit_cnt_q == 4'd0));

    // R1: STOP always returns to idle
    a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (state_q == S_IDLE && !sda_oe));

    // R2: an unmatched address is never acknowledged
    a_r2_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR && byte_end && !addr_hit && !ev.start && !ev.stop) |=> !sda_oe);

    // R5: the pointer wraps after the last register
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && ptr_q == LAST_A && !ev.start && !ev.stop) |=> (ptr_q == '0));

    // R9: a host NACK releases the line and parks the controller
    a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RACK && ev.scl_fall && !mack_q && !ev.start && !ev.stop)
        |=> (state_q == S_HOLD && !sda_oe));

endmodule

// File: rtl/vcfg_i2c_slave.sv
module vcfg_i2c_slave
    import vcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         NUM_REGS    = 28,
    parameter int         SAT_ADDR    = 5,
    parameter logic [7:0] SAT_INIT    = 8'h9D,
    parameter logic [7:0] ID_VALUE    = 8'h12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);

    localparam int PTR_W = $clog2(NUM_REGS);

    vcfg_bus_ev_t     ev;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] rd_addr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    vcfg_line_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    vcfg_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    vcfg_regfile #(
        .NUM_REGS (NUM_REGS),
        .PTR_W    (PTR_W),
        .SAT_ADDR (SAT_ADDR),
        .SAT_INIT (SAT_INIT),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/vcfg_i2c_slave_tb.sv
module vcfg_i2c_slave_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         NREG       = 28;
    localparam int         LAST       = NREG - 1;
    localparam logic [6:0] DEV        = 7'h44;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg;

    int n_chk = 0;
    int n_bad = 0;
    int oe_cnt;
    int mptr  = 0;
    logic [7:0] exp_regs [NREG];

    assign sda_line = sda_m & ~sda_oe;

    vcfg_i2c_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    // ---------------- reference model ----------------
    function automatic int nxt_ptr(int p);
        return (p == LAST) ? 0 : p + 1;
    endfunction

    function automatic int load_ptr(int b);
        return (b < NREG) ? b : 0;
    endfunction

    function automatic void model_write(int p, logic [7:0] d);
        if (p != LAST) exp_regs[p] = d;
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < NREG; k++) exp_regs[k] = (k == 5) ? 8'h9D : 8'h00;
        exp_regs[LAST] = 8'h12;
    endfunction

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_cfg(input string tag);
        int bad_k = -1;
        for (int k = 0; k < NREG; k++)
            if (bad_k < 0 && cfg[k*8 +: 8] !== exp_regs[k]) bad_k = k;
        if (bad_k < 0) check(1'b1, tag, 0, 0);
        else check(1'b0, {tag, " reg mismatch"}, int'(cfg[bad_k*8 +: 8]), int'(exp_regs[bad_k]));
    endtask

    // ---------------- bus master ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        tick(5); sda_m = b; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0;
    endtask

    task automatic recv_bit(output bit b);
        tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5); b = sda_line; tick(5); scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
    endtask

    task automatic write_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic open_write(input logic [7:0] pb);
        bit a;
        i2c_start();
        write_byte({DEV, 1'b0}, a);
        check(a, "R2 address write ack", a, 1);
        write_byte(pb, a);
        check(a, "R3 pointer ack", a, 1);
        mptr = load_ptr(int'(pb));
    endtask

    task automatic put_byte(input logic [7:0] d);
        bit a;
        write_byte(d, a);
        check(a, "R4 data ack", a, 1);
        model_write(mptr, d);
        mptr = nxt_ptr(mptr);
    endtask

    task automatic open_read();
        bit a;
        i2c_start();
        write_byte({DEV, 1'b1}, a);
        check(a, "R8 address read ack", a, 1);
    endtask

    task automatic get_byte(input bit more, input string tag);
        logic [7:0] v;
        read_byte(more, v);
        check(v == exp_regs[mptr], tag, int'(v), int'(exp_regs[mptr]));
        mptr = nxt_ptr(mptr);
    endtask

    // ---------------- scenarios ----------------
    task automatic run_all();
        bit a;
        int base;
        int p;
        int n;
        model_reset();
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R7 reset state
        check_cfg("R7 reset values");
        check(cfg[5*8 +: 8] == 8'h9D, "R7 saturation default", int'(cfg[5*8 +: 8]), 8'h9D);
        check(cfg[LAST*8 +: 8] == 8'h12, "R6 identity value", int'(cfg[LAST*8 +: 8]), 8'h12);
        check(sda_oe == 1'b0, "R7 line released", int'(sda_oe), 0);

        // R2/R3/R4/R10 simple write
        open_write(8'h02);
        put_byte(8'hAA);
        put_byte(8'h3C);
        i2c_stop();
        check_cfg("R10 bus after write");

        // R2 wrong address: no ack, no drive, no effect
        base = oe_cnt;
        i2c_start();
        write_byte({7'h45, 1'b0}, a);
        check(!a, "R2 foreign address nack", a, 0);
        write_byte(8'h03, a);
        write_byte(8'h55, a);
        check(oe_cnt == base, "R2 no drive after miss", oe_cnt - base, 0);
        i2c_stop();
        check_cfg("R2 registers untouched after miss");

        // R2 general call
        base = oe_cnt;
        i2c_start();
        write_byte(8'h00, a);
        check(!a, "R2 general call nack", a, 0);
        write_byte(8'h01, a);
        check(oe_cnt == base, "R2 general call no drive", oe_cnt - base, 0);
        i2c_stop();
        check_cfg("R2 registers untouched after general call");

        // R5/R6 write across the wrap
        open_write(8'h1A);
        put_byte(8'h71);
        put_byte(8'hEE);
        put_byte(8'h4B);
        i2c_stop();
        check_cfg("R5 R6 write wrap");
        check(cfg[LAST*8 +: 8] == 8'h12, "R6 identity survives write", int'(cfg[LAST*8 +: 8]), 8'h12);
        check(cfg[7:0] == 8'h4B, "R5 wrap lands at 0", int'(cfg[7:0]), 8'h4B);

        // R8/R5/R6/R9 read across the wrap, then NACK
        open_write(8'h1A);
        open_read();
        get_byte(1'b1, "R8 read 0x1A");
        get_byte(1'b1, "R6 read identity");
        get_byte(1'b0, "R5 read wrapped to 0");
        base = oe_cnt;
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        check(oe_cnt == base, "R9 released after nack", oe_cnt - base, 0);
        i2c_stop();

        // R3 out-of-range pointer loads 0
        open_write(8'h30);
        open_read();
        get_byte(1'b0, "R3 out-of-range pointer reads reg 0");
        i2c_stop();

        // R1 STOP mid-byte, then bits without START
        open_write(8'h04);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        i2c_stop();
        base = oe_cnt;
        scl_m = 1'b0;
        for (int i = 0; i < 18; i++) send_bit(i[0]);
        tick(5); scl_m = 1'b1; tick(5); sda_m = 1'b1; tick(10);
        check(oe_cnt == base, "R1 silent after stop", oe_cnt - base, 0);
        check_cfg("R1 no write after stop");

        // R1 repeated START mid-byte
        open_write(8'h03);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        open_write(8'h04);
        put_byte(8'h5A);
        i2c_stop();
        check_cfg("R1 restart mid-byte");

        // random bursts with read-back
        for (int it = 0; it < 14; it++) begin
            p = int'($urandom_range(0, LAST));
            n = int'($urandom_range(1, 6));
            open_write(8'(p));
            for (int j = 0; j < n; j++) put_byte(8'($urandom));
            i2c_stop();
            check_cfg("R10 bus after random burst");
            open_write(8'(p));
            open_read();
            for (int j = 0; j < n; j++) get_byte(j < n - 1, "R8 random read back");
            i2c_stop();
        end
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        void'($urandom(32'h5EED));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule